// File: doc/BRIEF.md
# Circular Receive Buffer Descriptor Fetcher

This block hands fresh receive buffers to the packet buffering logic. Host software places buffer descriptors in a circular queue in system memory, bounded by a start and an end address, and moves a write pointer past the entries it has filled. When the buffering logic asks for a new buffer, the block reads the descriptor at its own read pointer. The read goes through a valid/ready memory request channel and a valid/ready response channel. The block then loads a current buffer address and a remaining word count, and steps the read pointer on, wrapping at the end of the queue.

Each descriptor holds four 16-bit fields at consecutive memory units. The unit is a 2-byte word in 16-bit mode and a 4-byte long word in 32-bit mode. In 32-bit mode only the low half of each returned long word carries the field. The block never writes to memory. When the queue holds no descriptor, a fetch request raises an out-of-resources pulse and leaves the buffer registers as they are.

The request channel allows one outstanding read. The block holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` accepts them. It then raises `mem_rsp_ready` and waits for `mem_rsp_valid`, and a beat transfers on a cycle where both are high. The memory side may stall either channel for any number of cycles.

Top module: `rx_desc_fetcher`

## Requirements
- R1: After reset, buffer address, word count and all pointers read as zero, `load_done`, `out_of_res` and `busy` are low, and `empty` is high.
- R2: A host write with `hreg_sel` 0, 1, 2 or 3 loads start, end, read pointer or write pointer. Bit 0 is cleared in 16-bit mode and bits 1:0 are cleared in 32-bit mode. A read pointer write is ignored while `busy` is high.
- R3: `empty` is high exactly when the read pointer equals the write pointer.
- R4: A fetch request while empty raises `out_of_res` for one cycle. It issues no memory request and leaves the buffer address and word count unchanged.
- R5: A fetch issues four reads at read pointer + k*unit for k = 0..3, in this order: buffer address low, buffer address high, word count low, word count high. The unit is 2 in 16-bit mode and 4 in 32-bit mode.
- R6: The request stays valid with a stable address until accepted. Only one read is outstanding, and `mem_rsp_ready` is high only while no request is pending.
- R7: Only bits 15:0 of each response are used; bits above are ignored.
- R8: Buffer address = {field1, field0} and word count = {field3, field2}. Both change together in the cycle after the last response handshake, and `load_done` pulses high in that same cycle.
- R9: On that same edge the read pointer advances by 8 in 16-bit mode or 16 in 32-bit mode.
- R10: If the advanced read pointer is at or beyond the end address, the read pointer becomes the start address instead.
- R11: A fetch request while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode |
| hreg_we | input | 1 | Host register write strobe |
| hreg_sel | input | 2 | 0 start, 1 end, 2 read pointer, 3 write pointer |
| hreg_wdata | input | 32 | Host write data (byte address) |
| rd_ptr_o | output | 32 | Current read pointer |
| empty | output | 1 | Queue empty |
| fetch_req | input | 1 | Request for a new buffer |
| busy | output | 1 | Fetch in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Ready for read data |
| mem_rsp_data | input | 32 | Read data |
| buf_addr | output | 32 | Current buffer address |
| buf_wcount | output | 32 | Remaining buffer size in 2-byte words |
| load_done | output | 1 | New buffer registers valid (pulse) |
| out_of_res | output | 1 | Fetch refused, queue empty (pulse) |

## Verification
The hardest case to reach is a read pointer write arriving in the middle of a fetch. The write has to land after the first read has been issued but before the final response. The bench therefore issues the write right after raising the fetch request, while the memory model still stalls the request and response channels for random spans. It then checks that the pointer lands on the advanced value, and it sends a second fetch request during the same busy window. Wrap-around is reached by placing the read pointer in the last slot of queues of random length in both width modes.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2
  } fetch_state_t;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_RDPTR = 2'd2,
    SEL_WRPTR = 2'd3
  } reg_sel_t;

  localparam int unsigned FIELD_W  = 16;
  localparam int unsigned N_FIELDS = 4;
endpackage

// File: rtl/rdf_ptr_regs.sv
module rdf_ptr_regs
  import rdf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          busy,
  input  logic          advance,
  output logic [AW-1:0] rd_ptr,
  output logic          empty
);
  localparam logic [AW-1:0] STEP_NARROW = AW'(2 * N_FIELDS);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(4 * N_FIELDS);

  logic [AW-1:0] start_q, end_q, rd_q, wr_q;
  logic [AW-1:0] align_mask, wval, step, stepped, rd_next;

  assign align_mask = wide ? ~AW'(3) : ~AW'(1);
  assign wval       = wdata & align_mask;
  assign step       = wide ? STEP_WIDE : STEP_NARROW;
  assign stepped    = rd_q + step;
  assign rd_next    = (stepped >= end_q) ? start_q : stepped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      if (advance) rd_q <= rd_next;
      if (we) begin
        case (reg_sel_t'(sel))
          SEL_START: start_q <= wval;
          SEL_END:   end_q   <= wval;
          SEL_RDPTR: if (!busy) rd_q <= wval;
          SEL_WRPTR: wr_q    <= wval;
          default: ;
        endcase
      end
    end
  end

  assign rd_ptr = rd_q;
  assign empty  = (rd_q == wr_q);

  p_ptr_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (rd_q == $past(rd_q) + $past(step)) || (rd_q == $past(start_q)));

  p_rd_frozen_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> $stable(rd_q));

  p_rd_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q[0] == 1'b0);
endmodule

// File: rtl/rdf_fetch_fsm.sv
module rdf_fetch_fsm
  import rdf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide,
  input  logic               fetch_req,
  input  logic               empty,
  input  logic [AW-1:0]      base,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_addr,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [FIELD_W-1:0] rsp_field,
  output logic [2*FIELD_W-1:0] buf_addr,
  output logic [2*FIELD_W-1:0] buf_wcount,
  output logic               load_done,
  output logic               out_of_res,
  output logic               busy,
  output logic               advance
);
  localparam int unsigned IW = $clog2(N_FIELDS);

  fetch_state_t state;
  logic [IW-1:0] idx;
  logic [N_FIELDS-2:0][FIELD_W-1:0] fields;
  logic [AW-1:0] offset;
  logic last_beat;

  assign offset    = wide ? (AW'(idx) << 2) : (AW'(idx) << 1);
  assign req_addr  = base + offset;
  assign req_valid = (state == F_REQ);
  assign rsp_ready = (state == F_WAIT);
  assign busy      = (state != F_IDLE);
  assign last_beat = (state == F_WAIT) && rsp_valid && (idx == IW'(N_FIELDS - 1));
  assign advance   = last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= F_IDLE;
      idx        <= '0;
      fields     <= '0;
      buf_addr   <= '0;
      buf_wcount <= '0;
      load_done  <= 1'b0;
      out_of_res <= 1'b0;
    end else begin
      load_done  <= 1'b0;
      out_of_res <= 1'b0;
      case (state)
        F_IDLE: begin
          if (fetch_req) begin
            if (empty) out_of_res <= 1'b1;
            else begin
              idx   <= '0;
              state <= F_REQ;
            end
          end
        end
        F_REQ: if (req_ready) state <= F_WAIT;
        F_WAIT: begin
          if (rsp_valid) begin
            if (last_beat) begin
              buf_addr   <= {fields[1], fields[0]};
              buf_wcount <= {rsp_field, fields[2]};
              load_done  <= 1'b1;
              state      <= F_IDLE;
            end else begin
              fields[idx] <= rsp_field;
              idx         <= idx + 1'b1;
              state       <= F_REQ;
            end
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_res |-> (!req_valid && !rsp_ready && !load_done));

  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_IDLE) |=> $stable(buf_addr) && $stable(buf_wcount));
endmodule

// File: rtl/rx_desc_fetcher.sv
module rx_desc_fetcher
  import rdf_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          hreg_we,
  input  logic [1:0]    hreg_sel,
  input  logic [AW-1:0] hreg_wdata,
  output logic [AW-1:0] rd_ptr_o,
  output logic          empty,
  input  logic          fetch_req,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [2*FIELD_W-1:0] buf_addr,
  output logic [2*FIELD_W-1:0] buf_wcount,
  output logic          load_done,
  output logic          out_of_res
);
  logic advance;
  logic unused_rsp_hi;

  assign unused_rsp_hi = ^mem_rsp_data[DW-1:FIELD_W];

  rdf_ptr_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (wide_mode),
    .we      (hreg_we),
    .sel     (hreg_sel),
    .wdata   (hreg_wdata),
    .busy    (busy),
    .advance (advance),
    .rd_ptr  (rd_ptr_o),
    .empty   (empty)
  );

  rdf_fetch_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide_mode),
    .fetch_req  (fetch_req),
    .empty      (empty),
    .base       (rd_ptr_o),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr),
    .rsp_valid  (mem_rsp_valid),
    .rsp_ready  (mem_rsp_ready),
    .rsp_field  (mem_rsp_data[FIELD_W-1:0]),
    .buf_addr   (buf_addr),
    .buf_wcount (buf_wcount),
    .load_done  (load_done),
    .out_of_res (out_of_res),
    .busy       (busy),
    .advance    (advance)
  );

  p_refuse_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && empty && !busy) |=> out_of_res && $stable(rd_ptr_o));
endmodule

// File: tb/rx_desc_fetcher_bench.sv
module rx_desc_fetcher_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic hreg_we = 1'b0;
  logic [1:0] hreg_sel = '0;
  logic [31:0] hreg_wdata = '0;
  logic [31:0] rd_ptr_o;
  logic empty, busy, fetch_req = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] buf_addr, buf_wcount;
  logic load_done, out_of_res;

  always #(CLK_P/2) clk = ~clk;

  rx_desc_fetcher u_rx_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .hreg_we(hreg_we), .hreg_sel(hreg_sel), .hreg_wdata(hreg_wdata),
    .rd_ptr_o(rd_ptr_o), .empty(empty), .fetch_req(fetch_req), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .buf_addr(buf_addr), .buf_wcount(buf_wcount),
    .load_done(load_done), .out_of_res(out_of_res)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;
  int req_count = 0;
  logic [31:0] exp_base = '0;
  int exp_idx = 0;
  logic [31:0] m_start, m_end, m_rd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] memlo(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'hA5C3;
  endfunction

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {~a[15:0] | 16'h0101, memlo(a)};
  endfunction

  function automatic logic [31:0] unit_of(input logic w);
    return w ? 32'd4 : 32'd2;
  endfunction

  function automatic logic [31:0] next_rd(input logic [31:0] rd, input logic w);
    logic [31:0] s;
    s = rd + 4 * unit_of(w);
    return (s >= m_end) ? m_start : s;
  endfunction

  // memory model: random back-pressure, random response latency
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [31:0] paddr = '0;
    bit held = 0;
    logic [31:0] haddr = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memw(paddr);
          pend = 0;
        end else dly--;
      end
      if (held) begin
        chk("R6 request held", {31'b0, mem_req_valid}, 32'd1);
        chk("R6 address stable", mem_req_addr, haddr);
      end
      held = 0;
      mem_req_ready = (!pend && ($urandom % 3 != 0));
      if (mem_req_valid && mem_req_ready) begin
        chk("R5 read address", mem_req_addr, exp_base + exp_idx * unit_of(wide_mode));
        exp_idx = (exp_idx + 1) % 4;
        req_count++;
        paddr = mem_req_addr;
        pend = 1;
        dly = $urandom % 3;
      end else if (mem_req_valid) begin
        held = 1;
        haddr = mem_req_addr;
      end
    end
  end

  task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    hreg_we = 1'b1; hreg_sel = sel; hreg_wdata = d;
    @(negedge clk);
    hreg_we = 1'b0;
  endtask

  task automatic setup(input logic w, input logic [31:0] s, input logic [31:0] e,
                       input logic [31:0] rd, input logic [31:0] wr);
    wide_mode = w;
    host_wr(2'd0, s); host_wr(2'd1, e); host_wr(2'd3, wr); host_wr(2'd2, rd);
    m_start = s; m_end = e; m_rd = rd;
  endtask

  task automatic pulse_fetch();
    @(negedge clk);
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic wait_load(input string tag);
    int n = 0;
    while (load_done !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(tag, {31'b0, load_done}, 32'd1);
  endtask

  task automatic check_load();
    logic [31:0] u;
    u = unit_of(wide_mode);
    chk("R7 R8 buffer address", buf_addr, {memlo(m_rd + u), memlo(m_rd)});
    chk("R7 R8 word count", buf_wcount, {memlo(m_rd + 3*u), memlo(m_rd + 2*u)});
    chk("R9 R10 read pointer", rd_ptr_o, next_rd(m_rd, wide_mode));
    m_rd = next_rd(m_rd, wide_mode);
  endtask

  task automatic fetch_check();
    exp_base = m_rd; exp_idx = 0;
    pulse_fetch();
    wait_load("R8 load_done");
    check_load();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] sa, sb, sw;
    int c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 buf_addr", buf_addr, 32'h0);
    chk("R1 buf_wcount", buf_wcount, 32'h0);
    chk("R1 rd_ptr", rd_ptr_o, 32'h0);
    chk("R1 flags", {28'b0, load_done, out_of_res, busy, empty}, 32'h1);

    // R2 alignment masking
    wide_mode = 1'b1; host_wr(2'd2, 32'h2003);
    chk("R2 wide mask", rd_ptr_o, 32'h2000);
    wide_mode = 1'b0; host_wr(2'd2, 32'h2003);
    chk("R2 narrow mask", rd_ptr_o, 32'h2002);

    // narrow mode basic fetches, then drain to empty
    setup(1'b0, 32'h1000, 32'h1020, 32'h1000, 32'h1010);
    chk("R3 not empty", {31'b0, empty}, 32'd0);
    fetch_check();
    fetch_check();
    chk("R3 empty at equal pointers", {31'b0, empty}, 32'd1);

    // R4 fetch while empty
    sa = buf_addr; sb = buf_wcount; c0 = req_count;
    pulse_fetch();
    chk("R4 out_of_res pulse", {31'b0, out_of_res}, 32'd1);
    @(negedge clk);
    chk("R4 out_of_res one cycle", {31'b0, out_of_res}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R4 no request", req_count, c0);
    chk("R4 buf_addr kept", buf_addr, sa);
    chk("R4 wcount kept", buf_wcount, sb);

    // R10 wrap from last slot (narrow)
    host_wr(2'd3, 32'h1008); host_wr(2'd2, 32'h1018); m_rd = 32'h1018;
    fetch_check();
    chk("R10 wrapped to start", rd_ptr_o, 32'h1000);

    // R2 read pointer write during busy, R11 fetch during busy
    setup(1'b1, 32'h4000, 32'h4040, 32'h4010, 32'h4000);
    exp_base = m_rd; exp_idx = 0; c0 = req_count;
    @(negedge clk); fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    chk("R2 busy seen", {31'b0, busy}, 32'd1);
    hreg_we = 1'b1; hreg_sel = 2'd2; hreg_wdata = 32'h4030;
    @(negedge clk); hreg_we = 1'b0;
    fetch_req = 1'b1;
    @(negedge clk); fetch_req = 1'b0;
    wait_load("R11 load_done");
    check_load();
    repeat (12) @(negedge clk);
    chk("R11 busy fetch ignored", req_count - c0, 32'd4);
    chk("R11 no second load", {30'b0, busy, load_done}, 32'd0);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic w;
      int n, k, j;
      logic [31:0] st;
      w = 1'($urandom % 2);
      n = 2 + int'($urandom % 5);
      k = int'($urandom % n);
      j = (k + 1 + int'($urandom % (n - 1))) % n;
      st = {16'h0, 4'h0, 8'($urandom), 4'h0} | 32'h0001_0000;
      sw = st + j * 4 * unit_of(w);
      setup(w, st, st + n * 4 * unit_of(w), st + k * 4 * unit_of(w), sw);
      fetch_check();
      chk("R3 empty flag", {31'b0, empty}, {31'b0, (m_rd == sw)});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule